// File: doc/BRIEF.md
# Programmable External Bus Cycle Timer

This block produces the control strobes for one external memory access at a time. A request names a direction (read or write) and a chip-select. Each chip-select has its own set of timing fields. Every timing value is an offset, counted in functional-clock cycles, from the first cycle of the access.

A chip-select strobe, an address-valid/latch strobe, an output-enable, a write-enable and a byte-enable are each driven low inside their programmed window. At the end of the cycle time every strobe is pulled back to its inactive level. There is one exception: when the next request is already waiting in the final cycle, the next access starts on the very next cycle, so a strobe that is low at the end of one access and starts low in the next never shows a high cycle between them.

Optional idle gaps can be placed between back-to-back accesses. There is one enable for a repeat access to the same chip-select and another for a change of chip-select. The gap enables and the gap length are taken from the configuration of the access that is finishing. An access-done pulse marks the end of each access.

Top module: `bus_cycle_timer`

## Requirements
- R1: During and after reset, with no request, all of `cs_n`, `adv_n`, `oe_n`, `we_n` and `be_n` are high, `acc_done` is low and `acc_ready` is high.
- R2: A request is taken in a cycle where `req_valid` and `acc_ready` are both high. The access occupies the following T cycles, numbered k = 0..T-1. T is the write or read cycle field of the chosen chip-select, scaled as in R3, and a value of 0 counts as 1. `be_n` is low for all T cycles. `acc_ready` is high when the block is idle and in cycle T-1 of an access, and low otherwise. Chip-select i's field sits at bits [i*W +: W] of each `cfg_*` port, where W is that field's width.
- R3: When `cfg_gran[i]` is 1, every on-time, off-time and cycle-time field of chip-select i is doubled. When it is 0, the fields are used as written. The gap length is never scaled.
- R4: `cs_n[c]` for the accessed chip-select c is low for the k with cs_on <= k < off, where off is the write or read deassertion field according to direction. Every other `cs_n` bit stays high.
- R5: `adv_n` is low for adv_on <= k < adv_off. `oe_n` is low only on reads, for oe_on <= k < oe_off. `we_n` is low only on writes, for we_on <= k < we_off.
- R6: A strobe whose scaled off-time is less than or equal to its scaled on-time never goes low.
- R7: A strobe whose off-time lies beyond T is forced high in the cycle after k = T-1, unless a new access starts in that cycle.
- R8: If a request is taken in cycle T-1 and no gap applies, the new access's k = 0 is the very next cycle. A strobe that is low at k = T-1 and low at the new k = 0 shows no high cycle in between. This holds for every read/write pairing.
- R9: Take the request that arrives in cycle T-1. If it is for the same chip-select and that chip-select's `cfg_gap_same` bit is set, or it is for a different chip-select and the `cfg_gap_diff` bit is set, and the gap length is nonzero, then that many cycles with every strobe high come before the next access. The bits and length used are those of the finishing access.
- R10: `acc_done` is high for exactly one cycle per access. That cycle is k = T-1 when no gap follows, or the last gap cycle when one does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Chip-select index of the request |
| cfg_cs_on | input | NUM_CS*4 | Chip-select on-time per chip-select |
| cfg_cs_rd_off | input | NUM_CS*5 | Chip-select off-time for reads |
| cfg_cs_wr_off | input | NUM_CS*5 | Chip-select off-time for writes |
| cfg_adv_on | input | NUM_CS*4 | Address-valid on-time |
| cfg_adv_off | input | NUM_CS*5 | Address-valid off-time |
| cfg_oe_on | input | NUM_CS*4 | Output-enable on-time |
| cfg_oe_off | input | NUM_CS*5 | Output-enable off-time |
| cfg_we_on | input | NUM_CS*4 | Write-enable on-time |
| cfg_we_off | input | NUM_CS*5 | Write-enable off-time |
| cfg_rd_cycle | input | NUM_CS*5 | Read cycle time |
| cfg_wr_cycle | input | NUM_CS*5 | Write cycle time |
| cfg_gran | input | NUM_CS | Timing scale: 0 = x1, 1 = x2 |
| cfg_gap_same | input | NUM_CS | Gap enable, same chip-select next |
| cfg_gap_diff | input | NUM_CS | Gap enable, other chip-select next |
| cfg_gap_len | input | NUM_CS*4 | Gap length in cycles |
| acc_ready | output | 1 | A request is taken this cycle if valid |
| cs_n | output | NUM_CS | Chip-select strobes, active low |
| adv_n | output | 1 | Address-valid/latch strobe, active low |
| oe_n | output | 1 | Output-enable, active low |
| we_n | output | 1 | Write-enable, active low |
| be_n | output | 1 | Byte-enable, active low |
| acc_done | output | 1 | One-cycle end-of-access pulse |

## Verification
The end-of-cycle forced deassertion and the start of a pipelined access fall in the same cycle boundary. The bench provokes this by presenting the next request exactly in the final cycle of an access. It does so with strobes whose off-time equals or exceeds the cycle time and whose on-time is zero, in same-direction, mixed-direction and single-cycle chains.

Each cycle is judged against a precomputed per-cycle strobe vector, which must show no high cycle across the boundary. The same boundary is also driven with gaps enabled. There the vector must switch to all-high gap cycles, and the done pulse must move to the end of the gap.

// File: rtl/ebt_pkg.sv
package ebt_pkg;
  localparam int ON_W  = 4;
  localparam int OFF_W = 5;
  localparam int GAP_W = 4;
  localparam int CNT_W = OFF_W + 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [ON_W-1:0]  cs_on;
    logic [OFF_W-1:0] cs_rd_off;
    logic [OFF_W-1:0] cs_wr_off;
    logic [ON_W-1:0]  adv_on;
    logic [OFF_W-1:0] adv_off;
    logic [ON_W-1:0]  oe_on;
    logic [OFF_W-1:0] oe_off;
    logic [ON_W-1:0]  we_on;
    logic [OFF_W-1:0] we_off;
    logic [OFF_W-1:0] rd_cyc;
    logic [OFF_W-1:0] wr_cyc;
    logic             gran;
    logic             gap_same;
    logic             gap_diff;
    logic [GAP_W-1:0] gap_len;
  } cs_cfg_t;

  // Apply the x1 / x2 granularity to a timing field.
  function automatic logic [CNT_W-1:0] scale_val(input logic [OFF_W-1:0] v,
                                                 input logic g);
    return g ? {v, 1'b0} : {1'b0, v};
  endfunction

  // Cycle length in clocks; a zero field still yields one cycle.
  function automatic logic [CNT_W-1:0] cycle_len(input logic [OFF_W-1:0] v,
                                                 input logic g);
    logic [CNT_W-1:0] t;
    t = scale_val(v, g);
    return (t == '0) ? CNT_W'(1) : t;
  endfunction

  // A strobe window [on, off), clipped by the cycle length.
  function automatic logic win_hit(input logic [CNT_W-1:0] cnt,
                                   input logic [CNT_W-1:0] on_t,
                                   input logic [CNT_W-1:0] off_t,
                                   input logic [CNT_W-1:0] len);
    return (cnt >= on_t) && (cnt < off_t) && (cnt < len);
  endfunction
endpackage

// File: rtl/ebt_cfg_sel.sv
module ebt_cfg_sel
  import ebt_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CSW-1:0]          sel,
  input  logic [NUM_CS*ON_W-1:0]  cs_on,
  input  logic [NUM_CS*OFF_W-1:0] cs_rd_off,
  input  logic [NUM_CS*OFF_W-1:0] cs_wr_off,
  input  logic [NUM_CS*ON_W-1:0]  adv_on,
  input  logic [NUM_CS*OFF_W-1:0] adv_off,
  input  logic [NUM_CS*ON_W-1:0]  oe_on,
  input  logic [NUM_CS*OFF_W-1:0] oe_off,
  input  logic [NUM_CS*ON_W-1:0]  we_on,
  input  logic [NUM_CS*OFF_W-1:0] we_off,
  input  logic [NUM_CS*OFF_W-1:0] rd_cyc,
  input  logic [NUM_CS*OFF_W-1:0] wr_cyc,
  input  logic [NUM_CS-1:0]       gran,
  input  logic [NUM_CS-1:0]       gap_same,
  input  logic [NUM_CS-1:0]       gap_diff,
  input  logic [NUM_CS*GAP_W-1:0] gap_len,
  output cs_cfg_t                 cfg
);
  cs_cfg_t per_cs [NUM_CS];

  for (genvar i = 0; i < NUM_CS; i++) begin : g_unpack
    assign per_cs[i].cs_on     = cs_on    [i*ON_W  +: ON_W];
    assign per_cs[i].cs_rd_off = cs_rd_off[i*OFF_W +: OFF_W];
    assign per_cs[i].cs_wr_off = cs_wr_off[i*OFF_W +: OFF_W];
    assign per_cs[i].adv_on    = adv_on   [i*ON_W  +: ON_W];
    assign per_cs[i].adv_off   = adv_off  [i*OFF_W +: OFF_W];
    assign per_cs[i].oe_on     = oe_on    [i*ON_W  +: ON_W];
    assign per_cs[i].oe_off    = oe_off   [i*OFF_W +: OFF_W];
    assign per_cs[i].we_on     = we_on    [i*ON_W  +: ON_W];
    assign per_cs[i].we_off    = we_off   [i*OFF_W +: OFF_W];
    assign per_cs[i].rd_cyc    = rd_cyc   [i*OFF_W +: OFF_W];
    assign per_cs[i].wr_cyc    = wr_cyc   [i*OFF_W +: OFF_W];
    assign per_cs[i].gran      = gran[i];
    assign per_cs[i].gap_same  = gap_same[i];
    assign per_cs[i].gap_diff  = gap_diff[i];
    assign per_cs[i].gap_len   = gap_len  [i*GAP_W +: GAP_W];
  end

  assign cfg = per_cs[sel];
endmodule

// File: rtl/ebt_seq.sv
module ebt_seq
  import ebt_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_wr,
  input  logic [CSW-1:0]   req_cs,
  input  logic [OFF_W-1:0] cyc_rd,
  input  logic [OFF_W-1:0] cyc_wr,
  input  logic             gran,
  input  logic             gap_same,
  input  logic             gap_diff,
  input  logic [GAP_W-1:0] gap_len,
  output logic             in_run,
  output logic             in_gap,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cyc_len,
  output logic [CSW-1:0]   cur_cs,
  output logic             cur_wr,
  output logic             acc_done,
  output logic             acc_ready
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [GAP_W-1:0] gcnt_q;
  logic [CSW-1:0]   cur_cs_q, nxt_cs_q;
  logic             cur_wr_q, nxt_wr_q;

  // Named internal events
  logic last_run, take, gap_sel, need_gap, gap_end;

  assign cyc_len  = cycle_len(cur_wr_q ? cyc_wr : cyc_rd, gran);
  assign last_run = (state_q == ST_RUN) && (cnt_q == cyc_len - CNT_W'(1));
  assign gap_sel  = (req_cs == cur_cs_q) ? gap_same : gap_diff;
  assign need_gap = last_run && req_valid && gap_sel && (gap_len != '0);
  assign gap_end  = (state_q == ST_GAP) && (gcnt_q == '0);
  assign acc_ready = (state_q == ST_IDLE) || last_run;
  assign take      = req_valid && acc_ready;
  assign acc_done  = (last_run && !need_gap) || gap_end;

  assign in_run = (state_q == ST_RUN);
  assign in_gap = (state_q == ST_GAP);
  assign cnt    = cnt_q;
  assign cur_cs = cur_cs_q;
  assign cur_wr = cur_wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      gcnt_q   <= '0;
      cur_cs_q <= '0;
      cur_wr_q <= 1'b0;
      nxt_cs_q <= '0;
      nxt_wr_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          state_q  <= ST_RUN;
          cnt_q    <= '0;
          cur_cs_q <= req_cs;
          cur_wr_q <= req_wr;
        end
        ST_RUN: begin
          if (!last_run) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end else if (!req_valid) begin
            state_q <= ST_IDLE;
          end else if (need_gap) begin
            state_q  <= ST_GAP;
            gcnt_q   <= gap_len - GAP_W'(1);
            nxt_cs_q <= req_cs;
            nxt_wr_q <= req_wr;
          end else begin
            cnt_q    <= '0;
            cur_cs_q <= req_cs;
            cur_wr_q <= req_wr;
          end
        end
        ST_GAP: begin
          if (gcnt_q == '0) begin
            state_q  <= ST_RUN;
            cnt_q    <= '0;
            cur_cs_q <= nxt_cs_q;
            cur_wr_q <= nxt_wr_q;
          end else begin
            gcnt_q <= gcnt_q - GAP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !need_gap) |=> (in_run && cnt_q == '0));

  // R9
  gap_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need_gap |=> in_gap);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && !last_run) |=> (in_run && cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/ebt_strobe.sv
module ebt_strobe
  import ebt_pkg::*;
(
  input  logic             active,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] on_t,
  input  logic [CNT_W-1:0] off_t,
  input  logic [CNT_W-1:0] len,
  output logic             strobe_n
);
  logic hit;
  assign hit      = win_hit(cnt, on_t, off_t, len);
  assign strobe_n = !(active && hit);
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import ebt_pkg::*;
#(
  parameter int NUM_CS = 4,
  localparam int CSW = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_wr,
  input  logic [CSW-1:0]          req_cs,
  input  logic [NUM_CS*ON_W-1:0]  cfg_cs_on,
  input  logic [NUM_CS*OFF_W-1:0] cfg_cs_rd_off,
  input  logic [NUM_CS*OFF_W-1:0] cfg_cs_wr_off,
  input  logic [NUM_CS*ON_W-1:0]  cfg_adv_on,
  input  logic [NUM_CS*OFF_W-1:0] cfg_adv_off,
  input  logic [NUM_CS*ON_W-1:0]  cfg_oe_on,
  input  logic [NUM_CS*OFF_W-1:0] cfg_oe_off,
  input  logic [NUM_CS*ON_W-1:0]  cfg_we_on,
  input  logic [NUM_CS*OFF_W-1:0] cfg_we_off,
  input  logic [NUM_CS*OFF_W-1:0] cfg_rd_cycle,
  input  logic [NUM_CS*OFF_W-1:0] cfg_wr_cycle,
  input  logic [NUM_CS-1:0]       cfg_gran,
  input  logic [NUM_CS-1:0]       cfg_gap_same,
  input  logic [NUM_CS-1:0]       cfg_gap_diff,
  input  logic [NUM_CS*GAP_W-1:0] cfg_gap_len,
  output logic                    acc_ready,
  output logic [NUM_CS-1:0]       cs_n,
  output logic                    adv_n,
  output logic                    oe_n,
  output logic                    we_n,
  output logic                    be_n,
  output logic                    acc_done
);
  cs_cfg_t          cfg;
  logic             in_run, in_gap, cur_wr;
  logic [CNT_W-1:0] cnt, cyc_len;
  logic [CSW-1:0]   cur_cs;
  logic             cs_hit_n;
  logic [CNT_W-1:0] cs_on_s, cs_off_s, adv_on_s, adv_off_s;
  logic [CNT_W-1:0] oe_on_s, oe_off_s, we_on_s, we_off_s;

  ebt_cfg_sel #(.NUM_CS(NUM_CS)) u_cfg (
    .sel(cur_cs), .cs_on(cfg_cs_on), .cs_rd_off(cfg_cs_rd_off),
    .cs_wr_off(cfg_cs_wr_off), .adv_on(cfg_adv_on), .adv_off(cfg_adv_off),
    .oe_on(cfg_oe_on), .oe_off(cfg_oe_off), .we_on(cfg_we_on),
    .we_off(cfg_we_off), .rd_cyc(cfg_rd_cycle), .wr_cyc(cfg_wr_cycle),
    .gran(cfg_gran), .gap_same(cfg_gap_same), .gap_diff(cfg_gap_diff),
    .gap_len(cfg_gap_len), .cfg(cfg)
  );

  ebt_seq #(.NUM_CS(NUM_CS)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_cs(req_cs), .cyc_rd(cfg.rd_cyc), .cyc_wr(cfg.wr_cyc),
    .gran(cfg.gran), .gap_same(cfg.gap_same), .gap_diff(cfg.gap_diff),
    .gap_len(cfg.gap_len), .in_run(in_run), .in_gap(in_gap), .cnt(cnt),
    .cyc_len(cyc_len), .cur_cs(cur_cs), .cur_wr(cur_wr),
    .acc_done(acc_done), .acc_ready(acc_ready)
  );

  // Scaled window edges for the current access
  assign cs_on_s   = scale_val(OFF_W'(cfg.cs_on), cfg.gran);
  assign cs_off_s  = scale_val(cur_wr ? cfg.cs_wr_off : cfg.cs_rd_off, cfg.gran);
  assign adv_on_s  = scale_val(OFF_W'(cfg.adv_on), cfg.gran);
  assign adv_off_s = scale_val(cfg.adv_off, cfg.gran);
  assign oe_on_s   = scale_val(OFF_W'(cfg.oe_on), cfg.gran);
  assign oe_off_s  = scale_val(cfg.oe_off, cfg.gran);
  assign we_on_s   = scale_val(OFF_W'(cfg.we_on), cfg.gran);
  assign we_off_s  = scale_val(cfg.we_off, cfg.gran);

  ebt_strobe u_cs (.active(in_run), .cnt(cnt), .on_t(cs_on_s),
    .off_t(cs_off_s), .len(cyc_len), .strobe_n(cs_hit_n));
  ebt_strobe u_adv (.active(in_run), .cnt(cnt), .on_t(adv_on_s),
    .off_t(adv_off_s), .len(cyc_len), .strobe_n(adv_n));
  ebt_strobe u_oe (.active(in_run && !cur_wr), .cnt(cnt), .on_t(oe_on_s),
    .off_t(oe_off_s), .len(cyc_len), .strobe_n(oe_n));
  ebt_strobe u_we (.active(in_run && cur_wr), .cnt(cnt), .on_t(we_on_s),
    .off_t(we_off_s), .len(cyc_len), .strobe_n(we_n));
  ebt_strobe u_be (.active(in_run), .cnt(cnt), .on_t('0),
    .off_t(cyc_len), .len(cyc_len), .strobe_n(be_n));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign cs_n[i] = (cur_cs == CSW'(i)) ? cs_hit_n : 1'b1;
  end

  // R4
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R5
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R9
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_gap |-> ((&cs_n) && adv_n && oe_n && we_n && be_n));

  // R2
  be_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> !be_n);

  // R10
  done_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !in_gap);
endmodule

// File: tb/test_bus_cycle_timer.sv
`timescale 1ns/1ps
module test_bus_cycle_timer;
  localparam int NCS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       req_valid = 1'b0;
  logic       req_wr = 1'b0;
  logic [1:0] req_cs = '0;

  int b_cs_on[NCS], b_cs_rd_off[NCS], b_cs_wr_off[NCS];
  int b_adv_on[NCS], b_adv_off[NCS], b_oe_on[NCS], b_oe_off[NCS];
  int b_we_on[NCS], b_we_off[NCS], b_rd_cyc[NCS], b_wr_cyc[NCS];
  int b_gran[NCS], b_same[NCS], b_diff[NCS], b_glen[NCS];

  logic [NCS*4-1:0] f_cs_on, f_adv_on, f_oe_on, f_we_on, f_glen;
  logic [NCS*5-1:0] f_cs_rd_off, f_cs_wr_off, f_adv_off, f_oe_off, f_we_off;
  logic [NCS*5-1:0] f_rd_cyc, f_wr_cyc;
  logic [NCS-1:0]   f_gran, f_same, f_diff;

  always_comb begin
    for (int i = 0; i < NCS; i++) begin
      f_cs_on[i*4 +: 4]     = 4'(b_cs_on[i]);
      f_adv_on[i*4 +: 4]    = 4'(b_adv_on[i]);
      f_oe_on[i*4 +: 4]     = 4'(b_oe_on[i]);
      f_we_on[i*4 +: 4]     = 4'(b_we_on[i]);
      f_glen[i*4 +: 4]      = 4'(b_glen[i]);
      f_cs_rd_off[i*5 +: 5] = 5'(b_cs_rd_off[i]);
      f_cs_wr_off[i*5 +: 5] = 5'(b_cs_wr_off[i]);
      f_adv_off[i*5 +: 5]   = 5'(b_adv_off[i]);
      f_oe_off[i*5 +: 5]    = 5'(b_oe_off[i]);
      f_we_off[i*5 +: 5]    = 5'(b_we_off[i]);
      f_rd_cyc[i*5 +: 5]    = 5'(b_rd_cyc[i]);
      f_wr_cyc[i*5 +: 5]    = 5'(b_wr_cyc[i]);
      f_gran[i] = b_gran[i][0];
      f_same[i] = b_same[i][0];
      f_diff[i] = b_diff[i][0];
    end
  end

  logic           acc_ready, adv_n, oe_n, we_n, be_n, acc_done;
  logic [NCS-1:0] cs_n;

  bus_cycle_timer #(.NUM_CS(NCS)) i_bus_cycle_timer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_wr(req_wr),
    .req_cs(req_cs), .cfg_cs_on(f_cs_on), .cfg_cs_rd_off(f_cs_rd_off),
    .cfg_cs_wr_off(f_cs_wr_off), .cfg_adv_on(f_adv_on),
    .cfg_adv_off(f_adv_off), .cfg_oe_on(f_oe_on), .cfg_oe_off(f_oe_off),
    .cfg_we_on(f_we_on), .cfg_we_off(f_we_off), .cfg_rd_cycle(f_rd_cyc),
    .cfg_wr_cycle(f_wr_cyc), .cfg_gran(f_gran), .cfg_gap_same(f_same),
    .cfg_gap_diff(f_diff), .cfg_gap_len(f_glen), .acc_ready(acc_ready),
    .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n), .be_n(be_n),
    .acc_done(acc_done)
  );

  typedef struct packed {
    logic [NCS-1:0] cs_n;
    logic adv_n, oe_n, we_n, be_n, done, ready;
  } vec_t;

  vec_t  expq[$];
  string tagq[$];
  int total = 0, bad = 0;
  logic mon_on = 1'b0;

  int ch_cs[8];
  logic ch_wr[8];
  int ch_n;

  function automatic int sc(int v, int g);
    return (g != 0) ? v * 2 : v;
  endfunction

  function automatic int tlen(int cs, logic wr);
    int t = sc(wr ? b_wr_cyc[cs] : b_rd_cyc[cs], b_gran[cs]);
    return (t < 1) ? 1 : t;
  endfunction

  function automatic logic inwin(int k, int on, int off, int t, int g);
    return (k >= sc(on, g)) && (k < sc(off, g)) && (k < t);
  endfunction

  function automatic vec_t idle_vec();
    vec_t v;
    v.cs_n = '1; v.adv_n = 1; v.oe_n = 1; v.we_n = 1; v.be_n = 1;
    v.done = 0; v.ready = 1;
    return v;
  endfunction

  function automatic vec_t acc_vec(int cs, logic wr, int k, logic gap_next);
    vec_t v;
    int t = tlen(cs, wr);
    int g = b_gran[cs];
    v = idle_vec();
    v.cs_n[cs] = !inwin(k, b_cs_on[cs], wr ? b_cs_wr_off[cs] : b_cs_rd_off[cs], t, g);
    v.adv_n = !inwin(k, b_adv_on[cs], b_adv_off[cs], t, g);
    v.oe_n  = !(!wr && inwin(k, b_oe_on[cs], b_oe_off[cs], t, g));
    v.we_n  = !(wr && inwin(k, b_we_on[cs], b_we_off[cs], t, g));
    v.be_n  = 1'b0;
    v.ready = (k == t - 1);
    v.done  = (k == t - 1) && !gap_next;
    return v;
  endfunction

  function automatic int gap_after(int cs, int nxt);
    int en = (cs == nxt) ? b_same[cs] : b_diff[cs];
    return (en != 0) ? b_glen[cs] : 0;
  endfunction

  task automatic check_field(string sig, string req, string scen, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (scenario %s) %s: actual=%0d expected=%0d", req, scen, sig, act, exp);
    end
  endtask

  task automatic cmp_vec(vec_t e, string s);
    check_field("cs_n", "R4", s, int'(cs_n), int'(e.cs_n));
    check_field("adv_n", "R5", s, int'(adv_n), int'(e.adv_n));
    check_field("oe_n", "R5", s, int'(oe_n), int'(e.oe_n));
    check_field("we_n", "R5", s, int'(we_n), int'(e.we_n));
    check_field("be_n", "R2", s, int'(be_n), int'(e.be_n));
    check_field("acc_done", "R10", s, int'(acc_done), int'(e.done));
    check_field("acc_ready", "R2", s, int'(acc_ready), int'(e.ready));
  endtask

  // Monitor: pops one expected vector per cycle; an empty queue means idle (R1)
  always @(negedge clk) begin
    vec_t  e;
    string s;
    if (mon_on) begin
      if (expq.size() > 0) begin
        e = expq.pop_front();
        s = tagq.pop_front();
      end else begin
        e = idle_vec();
        s = "R1";
      end
      cmp_vec(e, s);
    end
  end

  // Driver: pushes the full expected timeline, then drives the chain
  task automatic run_chain(string tag);
    int gaps[8];
    vec_t gv;
    for (int j = 0; j < ch_n; j++)
      gaps[j] = (j < ch_n - 1) ? gap_after(ch_cs[j], ch_cs[j+1]) : 0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_cs = 2'(ch_cs[0]); req_wr = ch_wr[0];
    expq.push_back(idle_vec()); tagq.push_back(tag);
    for (int j = 0; j < ch_n; j++) begin
      for (int k = 0; k < tlen(ch_cs[j], ch_wr[j]); k++) begin
        expq.push_back(acc_vec(ch_cs[j], ch_wr[j], k, gaps[j] != 0));
        tagq.push_back(tag);
      end
      for (int g = 0; g < gaps[j]; g++) begin
        gv = idle_vec();
        gv.ready = 1'b0;
        gv.done = (g == gaps[j] - 1);
        expq.push_back(gv); tagq.push_back(tag);
      end
    end
    expq.push_back(idle_vec()); tagq.push_back(tag);
    @(posedge clk); #1;
    for (int j = 0; j < ch_n; j++) begin
      for (int k = 0; k < tlen(ch_cs[j], ch_wr[j]); k++) begin
        if (k == tlen(ch_cs[j], ch_wr[j]) - 1 && j < ch_n - 1) begin
          req_valid = 1'b1; req_cs = 2'(ch_cs[j+1]); req_wr = ch_wr[j+1];
        end else begin
          req_valid = 1'b0;
        end
        @(posedge clk); #1;
      end
      if (gaps[j] > 0) begin
        req_valid = 1'b0;
        repeat (gaps[j]) @(posedge clk);
        #1;
      end
    end
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_cs(int i, int con, int croff, int cwoff, int aon, int aoff,
                        int oon, int ooff, int won, int woff, int rc, int wc,
                        int gr, int sm, int df, int gl);
    b_cs_on[i] = con; b_cs_rd_off[i] = croff; b_cs_wr_off[i] = cwoff;
    b_adv_on[i] = aon; b_adv_off[i] = aoff; b_oe_on[i] = oon; b_oe_off[i] = ooff;
    b_we_on[i] = won; b_we_off[i] = woff; b_rd_cyc[i] = rc; b_wr_cyc[i] = wc;
    b_gran[i] = gr; b_same[i] = sm; b_diff[i] = df; b_glen[i] = gl;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    set_cs(0, 1, 6, 5, 0, 2, 2, 6, 1, 4, 6, 5, 0, 0, 0, 0);
    set_cs(1, 1, 3, 4, 0, 1, 1, 3, 2, 3, 4, 4, 1, 1, 0, 3);
    set_cs(2, 0, 9, 3, 3, 2, 0, 9, 0, 3, 4, 3, 0, 0, 1, 2);
    set_cs(3, 0, 1, 1, 0, 1, 0, 1, 0, 1, 1, 1, 0, 0, 0, 0);
    repeat (2) @(negedge clk);
    // R1: outputs while reset is held
    cmp_vec(idle_vec(), "R1");
    @(posedge clk); #1;
    rst_n = 1'b1;
    mon_on = 1'b1;
    repeat (2) @(posedge clk);

    // R4 / R5: single read and single write on chip-select 0
    ch_n = 1; ch_cs[0] = 0; ch_wr[0] = 1'b0; run_chain("R4");
    ch_n = 1; ch_cs[0] = 0; ch_wr[0] = 1'b1; run_chain("R5");
    // R3: doubled timing on chip-select 1
    ch_n = 1; ch_cs[0] = 1; ch_wr[0] = 1'b0; run_chain("R3");
    // R7: chip-select and output-enable off-times beyond the cycle length
    ch_n = 1; ch_cs[0] = 2; ch_wr[0] = 1'b0; run_chain("R7");
    // R6: address strobe with off <= on never asserts
    ch_n = 1; ch_cs[0] = 2; ch_wr[0] = 1'b1; run_chain("R6");
    // R9: same chip-select gap of three cycles
    ch_n = 2; ch_cs[0] = 1; ch_wr[0] = 1'b0; ch_cs[1] = 1; ch_wr[1] = 1'b1;
    run_chain("R9");
    // R9: different chip-select gap of two cycles
    ch_n = 2; ch_cs[0] = 2; ch_wr[0] = 1'b1; ch_cs[1] = 0; ch_wr[1] = 1'b0;
    run_chain("R9");
    // R8: same chip-select, no gap, strobes continuous across the boundary
    ch_n = 2; ch_cs[0] = 2; ch_wr[0] = 1'b0; ch_cs[1] = 2; ch_wr[1] = 1'b0;
    run_chain("R8");
    // R8: one-cycle accesses, write/read/write/write chain
    ch_n = 4; ch_cs[0] = 3; ch_wr[0] = 1'b1; ch_cs[1] = 3; ch_wr[1] = 1'b0;
    ch_cs[2] = 3; ch_wr[2] = 1'b1; ch_cs[3] = 3; ch_wr[3] = 1'b1;
    run_chain("R8");
    // R8 / R10: change of chip-select with gap disabled
    ch_n = 3; ch_cs[0] = 1; ch_wr[0] = 1'b0; ch_cs[1] = 0; ch_wr[1] = 1'b0;
    ch_cs[2] = 3; ch_wr[2] = 1'b0;
    run_chain("R10");

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule